// File: doc/BRIEF.md
# Snoopy Cache Line Coherence Controller

This block holds the coherence state of every line of a snoopy write-back cache on a shared bus. It decides, for each event, which bus transaction the cache must issue, whether the cache drives the data by cache-to-cache intervention, and the state the line moves to. There are six states. One of them, clean owned shared, lets a clean line held by several caches keep one owner, and that owner answers later coherent reads by intervention instead of memory.

Each cycle carries at most one event on `ev_op` for the line selected by `ev_idx`. An event is either a local CPU action (read, write, replace) or a transaction snooped from the bus. The outputs are combinational from the stored state and the event. The new state is written at the next rising clock edge. `other_cached` is the bus's shared-line answer to the transaction this cache issues. It may steer the next state but never the issued transaction. The event code NONE leaves all state as it is and shows the selected line's state on `next_state`. Parameter `CLEAN_OWNER` (default 1) enables the clean owned shared state. With it at 0, a clean exclusive line that is read by another cache drops to clean shared.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0), and with `ev_op`=0 (NONE) `bus_op`=0 (none), `cci_en`=0 and `next_state` shows the selected line's stored state.
- R2: A CPU read (`ev_op`=1) of an Invalid line issues a coherent read (`bus_op`=1) and goes to clean exclusive (code 1) when `other_cached`=0, or to clean shared (code 3) when it is 1.
- R3: A CPU write (`ev_op`=2) of an Invalid line issues a coherent read-invalidate (`bus_op`=2) and goes to owned exclusive (code 2).
- R4: A CPU read of a valid line issues nothing and keeps the state. A CPU write of a clean exclusive or owned exclusive line issues nothing and goes to owned exclusive.
- R5: A CPU write of a clean shared, owned shared (code 4) or clean owned shared (code 5) line issues a coherent invalidate (`bus_op`=3) and goes to owned exclusive.
- R6: A snooped coherent read (`ev_op`=4) of an owned exclusive line raises `cci_en` and goes to owned shared. In owned shared it raises `cci_en` and stays there.
- R7: A snooped coherent read of a clean exclusive line raises `cci_en` and goes to clean owned shared, which then answers further snooped reads with `cci_en` and stays. A clean shared line stays clean shared without `cci_en`.
- R8: `cci_en` is raised only for a line in an owning state (codes 1, 2, 4, 5) on a snooped coherent read or read-invalidate. A snooped event (`ev_op` 4 to 8) never issues a bus transaction.
- R9: A snooped read-invalidate (`ev_op`=5), invalidate (6) or write-invalidate (8) moves the line to Invalid. An owner also raises `cci_en` on a read-invalidate.
- R10: A snooped write-back (`ev_op`=7) changes no state and raises nothing.
- R11: Replacing (`ev_op`=3) an owned exclusive or owned shared line issues a write-back (`bus_op`=4). Replacing a clean line issues nothing. Both go to Invalid.
- R12: Owned shared is entered only from owned exclusive, and clean owned shared only from clean exclusive.
- R13: An event changes only the line selected by `ev_idx`.
- R14: `bus_op` and `cci_en` do not depend on `other_cached`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_op | input | 4 | Event code: 0 none, 1 CPU read, 2 CPU write, 3 replace, 4 snoop read, 5 snoop read-invalidate, 6 snoop invalidate, 7 snoop write-back, 8 snoop write-invalidate |
| ev_idx | input | IDX_W | Line selected by the event |
| other_cached | input | 1 | Another cache holds the line, valid with this cache's bus transaction |
| bus_op | output | 3 | Transaction to issue: 0 none, 1 read, 2 read-invalidate, 3 invalidate, 4 write-back |
| cci_en | output | 1 | Drive the line's data by cache-to-cache intervention |
| next_state | output | 3 | State the selected line takes at the next edge |

## Verification
The hardest states to reach are the two shared owner states. Clean owned shared needs a read miss with no other sharer, and then a snooped read on the same line. Owned shared needs a write that reaches owned exclusive, and then a snooped read. The stimulus table walks one line through exactly these chains. It then checks that a repeated snooped read keeps the owner and keeps intervention on, and that a write to a shared owner issues an invalidate. Other lines are used in between, and the first line is read back afterwards to show it was not disturbed.

// File: rtl/snoop_line_pkg.sv
package snoop_line_pkg;

   typedef enum logic [2:0] {
      ST_INV         = 3'd0,
      ST_CLN_EXCL    = 3'd1,
      ST_DRT_EXCL    = 3'd2,
      ST_CLN_SHR     = 3'd3,
      ST_DRT_SHR     = 3'd4,
      ST_CLN_OWN_SHR = 3'd5
   } line_st_t;

   typedef enum logic [3:0] {
      EV_NONE     = 4'd0,
      EV_CPU_RD   = 4'd1,
      EV_CPU_WR   = 4'd2,
      EV_CPU_REPL = 4'd3,
      EV_SNP_RD   = 4'd4,
      EV_SNP_RDI  = 4'd5,
      EV_SNP_INV  = 4'd6,
      EV_SNP_WB   = 4'd7,
      EV_SNP_WRI  = 4'd8
   } ev_t;

   typedef enum logic [2:0] {
      BUS_NONE = 3'd0,
      BUS_RD   = 3'd1,
      BUS_RDI  = 3'd2,
      BUS_INV  = 3'd3,
      BUS_WB   = 3'd4
   } bus_t;

   function automatic logic is_owner(input line_st_t s);
      return (s == ST_CLN_EXCL) || (s == ST_DRT_EXCL) ||
             (s == ST_DRT_SHR)  || (s == ST_CLN_OWN_SHR);
   endfunction

   function automatic logic is_snoop(input ev_t e);
      return (e >= EV_SNP_RD) && (e <= EV_SNP_WRI);
   endfunction

   function automatic logic is_cpu(input ev_t e);
      return (e >= EV_CPU_RD) && (e <= EV_CPU_REPL);
   endfunction

endpackage

// File: rtl/cpu_xition.sv
module cpu_xition
   import snoop_line_pkg::*;
(
   input  line_st_t cur,
   input  ev_t      ev,
   input  logic     other_cached,
   output bus_t     bus,
   output line_st_t nxt
);

   // Issued transaction: a function of state and event only.
   always_comb begin
      bus = BUS_NONE;
      unique case (ev)
         EV_CPU_RD:   if (cur == ST_INV) bus = BUS_RD;
         EV_CPU_WR: begin
            if (cur == ST_INV) bus = BUS_RDI;
            else if ((cur == ST_CLN_SHR) || (cur == ST_DRT_SHR) ||
                     (cur == ST_CLN_OWN_SHR)) bus = BUS_INV;
         end
         EV_CPU_REPL: if ((cur == ST_DRT_EXCL) || (cur == ST_DRT_SHR)) bus = BUS_WB;
         default:     bus = BUS_NONE;
      endcase
   end

   // Next state: may use the shared-line answer of the bus.
   always_comb begin
      nxt = cur;
      unique case (ev)
         EV_CPU_RD:   if (cur == ST_INV) nxt = other_cached ? ST_CLN_SHR : ST_CLN_EXCL;
         EV_CPU_WR:   nxt = ST_DRT_EXCL;
         EV_CPU_REPL: nxt = ST_INV;
         default:     nxt = cur;
      endcase
   end

endmodule

// File: rtl/snoop_xition.sv
module snoop_xition
   import snoop_line_pkg::*;
#(
   parameter bit CLEAN_OWNER = 1'b1
)(
   input  line_st_t cur,
   input  ev_t      ev,
   output logic     cci,
   output line_st_t nxt
);

   line_st_t rd_hit_cln_excl;

   generate
      if (CLEAN_OWNER) begin : g_clean_owner
         assign rd_hit_cln_excl = ST_CLN_OWN_SHR;
      end else begin : g_no_clean_owner
         assign rd_hit_cln_excl = ST_CLN_SHR;
      end
   endgenerate

   always_comb begin
      cci = 1'b0;
      nxt = cur;
      unique case (ev)
         EV_SNP_RD: begin
            cci = is_owner(cur);
            unique case (cur)
               ST_CLN_EXCL: nxt = rd_hit_cln_excl;
               ST_DRT_EXCL: nxt = ST_DRT_SHR;
               default:     nxt = cur;
            endcase
         end
         EV_SNP_RDI: begin
            cci = is_owner(cur);
            nxt = ST_INV;
         end
         EV_SNP_INV, EV_SNP_WRI: nxt = ST_INV;
         default: begin
            cci = 1'b0;
            nxt = cur;
         end
      endcase
   end

endmodule

// File: rtl/line_state_array.sv
module line_state_array
   import snoop_line_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  line_st_t         wr_state,
   output line_st_t         rd_state
);

   line_st_t per_line [NUM_LINES];

   generate
      for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
         line_st_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= ST_INV;
            else if (wr_en && (idx == IDX_W'(g)))
               q <= wr_state;
         end
         assign per_line[g] = q;
      end
   endgenerate

   assign rd_state = per_line[idx];

endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl
   import snoop_line_pkg::*;
#(
   parameter int NUM_LINES   = 8,
   parameter bit CLEAN_OWNER = 1'b1,
   localparam int IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       ev_op,
   input  logic [IDX_W-1:0] ev_idx,
   input  logic             other_cached,
   output logic [2:0]       bus_op,
   output logic             cci_en,
   output logic [2:0]       next_state
);

   generate
      if (NUM_LINES < 2) begin : g_chk_lines
         $error("snoop_line_ctrl: NUM_LINES must be at least 2");
      end
      if ((NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_chk_pow2
         $error("snoop_line_ctrl: NUM_LINES must be a power of two");
      end
   endgenerate

   ev_t      ev;
   line_st_t cur;
   line_st_t nxt_cpu;
   line_st_t nxt_snp;
   line_st_t nxt;
   bus_t     bus;
   logic     cci;
   logic [2:0] cur_state;

   assign ev = ev_t'(ev_op);

   line_state_array #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ev != EV_NONE),
      .idx      (ev_idx),
      .wr_state (nxt),
      .rd_state (cur)
   );

   cpu_xition i_cpu (
      .cur          (cur),
      .ev           (ev),
      .other_cached (other_cached),
      .bus          (bus),
      .nxt          (nxt_cpu)
   );

   snoop_xition #(
      .CLEAN_OWNER (CLEAN_OWNER)
   ) i_snp (
      .cur (cur),
      .ev  (ev),
      .cci (cci),
      .nxt (nxt_snp)
   );

   always_comb begin
      if (is_snoop(ev))    nxt = nxt_snp;
      else if (is_cpu(ev)) nxt = nxt_cpu;
      else                 nxt = cur;
   end

   assign bus_op     = bus;
   assign cci_en     = cci;
   assign next_state = nxt;
   assign cur_state  = cur;

endmodule

// File: rtl/snoop_line_ctrl_chk.sv
module snoop_line_ctrl_chk #(
   parameter int IDX_W = 3
)(
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       ev_op,
   input logic [IDX_W-1:0] ev_idx,
   input logic [2:0]       bus_op,
   input logic             cci_en,
   input logic [2:0]       next_state,
   input logic [2:0]       cur_state
);

   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   assert_cci_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cci_en |-> (cur_state == 3'd1 || cur_state == 3'd2 ||
                  cur_state == 3'd4 || cur_state == 3'd5));

   assert_snoop_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_op >= 4'd4 && ev_op <= 4'd8) |-> (bus_op == 3'd0));

   assert_wb_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_op == 4'd7) |-> (next_state == cur_state && !cci_en));

   assert_os_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (next_state == 3'd4 && cur_state != 3'd4) |-> (cur_state == 3'd2));

   assert_cos_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (next_state == 3'd5 && cur_state != 3'd5) |-> (cur_state == 3'd1));

   assert_write_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_op == 4'd2 && cur_state == 3'd0) |-> (bus_op == 3'd2 && next_state == 3'd2));

   assert_invalidate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_op == 4'd5 || ev_op == 4'd6 || ev_op == 4'd8) |-> (next_state == 3'd0));

   assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && ev_op == 4'd0 && $past(ev_idx) == ev_idx) |->
         (next_state == $past(next_state)));

endmodule

bind snoop_line_ctrl snoop_line_ctrl_chk #(.IDX_W(IDX_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_op      (ev_op),
   .ev_idx     (ev_idx),
   .bus_op     (bus_op),
   .cci_en     (cci_en),
   .next_state (next_state),
   .cur_state  (cur_state)
);

// File: tb/test_snoop_line_ctrl.sv
module test_snoop_line_ctrl;

   localparam int NL = 8;
   localparam int IW = 3;
   localparam int NV = 30;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    ev_op = 4'd0;
   logic [IW-1:0] ev_idx = '0;
   logic          other_cached = 1'b0;
   logic [2:0]    bus_op;
   logic          cci_en;
   logic [2:0]    next_state;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   snoop_line_ctrl #(.NUM_LINES(NL), .CLEAN_OWNER(1'b1)) i_snoop_line_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_op        (ev_op),
      .ev_idx       (ev_idx),
      .other_cached (other_cached),
      .bus_op       (bus_op),
      .cci_en       (cci_en),
      .next_state   (next_state)
   );

   // {op[4], idx[3], oc[1], bus[3], cci[1], next[3], req[4]}
   localparam logic [18:0] VEC [NV] = '{
      {4'd0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 4'd1},  // R1 idle after reset
      {4'd1, 3'd0, 1'b0, 3'd1, 1'b0, 3'd1, 4'd2},  // R2 read miss alone -> CE
      {4'd1, 3'd0, 1'b1, 3'd0, 1'b0, 3'd1, 4'd4},  // R4 read hit, R14 oc ignored
      {4'd4, 3'd0, 1'b0, 3'd0, 1'b1, 3'd5, 4'd7},  // R7 CE -> COS, R12
      {4'd4, 3'd0, 1'b0, 3'd0, 1'b1, 3'd5, 4'd7},  // R7 COS keeps ownership
      {4'd7, 3'd0, 1'b0, 3'd0, 1'b0, 3'd5, 4'd10}, // R10 write-back ignored
      {4'd2, 3'd0, 1'b0, 3'd3, 1'b0, 3'd2, 4'd5},  // R5 COS write -> invalidate
      {4'd2, 3'd0, 1'b1, 3'd0, 1'b0, 3'd2, 4'd4},  // R4 OE write silent
      {4'd4, 3'd0, 1'b0, 3'd0, 1'b1, 3'd4, 4'd6},  // R6 OE -> OS, R12
      {4'd4, 3'd0, 1'b0, 3'd0, 1'b1, 3'd4, 4'd6},  // R6 OS stays owner
      {4'd3, 3'd0, 1'b0, 3'd4, 1'b0, 3'd0, 4'd11}, // R11 OS replace -> write-back
      {4'd2, 3'd1, 1'b1, 3'd2, 1'b0, 3'd2, 4'd3},  // R3 write miss
      {4'd0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 4'd13}, // R13 line 0 untouched
      {4'd5, 3'd1, 1'b0, 3'd0, 1'b1, 3'd0, 4'd9},  // R9 owner read-invalidate
      {4'd1, 3'd2, 1'b1, 3'd1, 1'b0, 3'd3, 4'd2},  // R2 read miss shared -> CS
      {4'd4, 3'd2, 1'b0, 3'd0, 1'b0, 3'd3, 4'd7},  // R7 CS no intervention
      {4'd2, 3'd2, 1'b0, 3'd3, 1'b0, 3'd2, 4'd5},  // R5 CS write -> invalidate
      {4'd1, 3'd3, 1'b0, 3'd1, 1'b0, 3'd1, 4'd2},  // R2 CE on line 3
      {4'd3, 3'd3, 1'b0, 3'd0, 1'b0, 3'd0, 4'd11}, // R11 clean replace silent
      {4'd1, 3'd3, 1'b0, 3'd1, 1'b0, 3'd1, 4'd2},  // R2 again CE
      {4'd6, 3'd3, 1'b0, 3'd0, 1'b0, 3'd0, 4'd9},  // R9 snoop invalidate
      {4'd1, 3'd4, 1'b1, 3'd1, 1'b0, 3'd3, 4'd2},  // R2 CS on line 4
      {4'd8, 3'd4, 1'b0, 3'd0, 1'b0, 3'd0, 4'd9},  // R9 write-invalidate
      {4'd4, 3'd5, 1'b0, 3'd0, 1'b0, 3'd0, 4'd8},  // R8 snoop read on Invalid
      {4'd1, 3'd6, 1'b1, 3'd1, 1'b0, 3'd3, 4'd2},  // R2 CS on line 6
      {4'd7, 3'd6, 1'b0, 3'd0, 1'b0, 3'd3, 4'd10}, // R10 write-back on CS
      {4'd3, 3'd6, 1'b0, 3'd0, 1'b0, 3'd0, 4'd11}, // R11 CS replace silent
      {4'd0, 3'd2, 1'b0, 3'd0, 1'b0, 3'd2, 4'd13}, // R13 line 2 still OE
      {4'd2, 3'd7, 1'b0, 3'd2, 1'b0, 3'd2, 4'd14}, // R14 write miss oc=0 same
      {4'd5, 3'd7, 1'b0, 3'd0, 1'b1, 3'd0, 4'd9}   // R9 OE read-invalidate
   };

   task automatic check(input string req, input logic [2:0] eb, input logic ec,
                        input logic [2:0] en);
      checks++;
      if (bus_op !== eb || cci_en !== ec || next_state !== en) begin
         errors++;
         $display("FAIL %s: bus=%0d cci=%0d next=%0d expected bus=%0d cci=%0d next=%0d",
                  req, bus_op, cci_en, next_state, eb, ec, en);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [IW-1:0] idx, input logic oc);
      @(negedge clk);
      ev_op = op;
      ev_idx = idx;
      other_cached = oc;
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         logic [18:0] w;
         w = VEC[v];
         apply(w[18:15], w[14:12], w[11]);
         check($sformatf("R%0d vec%0d", w[3:0], v), w[10:8], w[7], w[6:4]);
      end

      // R14: read miss with other_cached toggled within the cycle keeps bus_op
      apply(4'd1, 3'd5, 1'b0);
      check("R14 oc=0", 3'd1, 1'b0, 3'd1);
      other_cached = 1'b1;
      #1;
      check("R14 oc=1", 3'd1, 1'b0, 3'd3);

      // R1: reset in the middle of activity clears every line
      apply(4'd2, 3'd6, 1'b0);
      @(negedge clk);
      ev_op = 4'd0;
      rst_n = 1'b0;
      #1;
      check("R1 idle in reset", 3'd0, 1'b0, 3'd0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int l = 0; l < NL; l++) begin
         apply(4'd0, IW'(l), 1'b0);
         check($sformatf("R1 line%0d", l), 3'd0, 1'b0, 3'd0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule